// File: doc/BRIEF.md
# Stub level-two cache controller register block

This block gives software a level-two cache controller register view without any cache array behind it. Driver code can probe the controller's identity and geometry, program its enable, latency and address-filter settings, and start maintenance operations. Every maintenance operation reports itself finished at once. The block sits on a single-cycle register bus with address, write enable, write data, read enable and read data, and it decodes one 4 KB window.

A read of the geometry word takes four bits from the auxiliary-control register and merges them into a stored word, so the word keeps all bits ever merged until reset. An access to an offset with no meaning returns zero, changes nothing, and raises a one-cycle error pulse.

Top module: `stub_l2_regs`

## Requirements
- R1: Only address bits 11:0 are decoded, so the register set repeats every 0x1000 bytes whatever the upper address bits are.
- R2: Offset 0x000 always reads 0x410000C8. A write to it changes nothing and raises no error.
- R3: A write to offset 0x100 (control) stores only bit 0. A read of control returns zero in bits 31:1.
- R4: Offsets 0x104 (auxiliary control), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) each store and return a full 32-bit value.
- R5: After reset, auxiliary control holds 0x02020000, the geometry word holds the TYPE_RESET parameter (default 0x1C100100), and control, tag latency, data latency and both filter registers hold zero.
- R6: A read of offset 0x004 forms a code whose bits 3:1 are auxiliary-control bits 19:17 and whose bit 0 is auxiliary-control bit 16. It ORs that code into bits 21:18 and into bits 9:6 of the stored geometry word and returns the merged value. The first read after reset returns 0x1C180180.
- R7: Bits set in the geometry word stay set across later reads and auxiliary-control writes until reset.
- R8: Any access to offsets 0x730 through 0x7FF reads zero, leaves state unchanged, and raises no error. Offsets 0x72C and 0x800 are not part of this range.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read zero, ignore writes and raise no error.
- R10: A read or write to any other offset returns zero and changes no register. It also drives bus_err high for exactly the one cycle after the access.
- R11: bus_rdata is registered. It carries the read value in the cycle after bus_re and is zero in the cycle after a cycle without bus_re. A read and a write to the same register in one cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 11:0 are decoded |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
Every cycle, the assertions check the constant identity value, the zero upper bits of control, the zero reads from the maintenance and reserved offsets, and zero data after idle cycles. They also check that the error pulse matches an independent decode of the mapped offsets and that the stored geometry word never loses a bit. Only the directed scenarios can show that the five full-width registers retain written values and that the window aliases. They also show that the geometry word builds up its value from a sequence of auxiliary-control settings, and that a read in the same cycle as a write returns the old contents.

// File: rtl/stub_l2_pkg.sv
package stub_l2_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    localparam logic [OFF_W-1:0] OFF_ID      = 12'h000;
    localparam logic [OFF_W-1:0] OFF_TYPE    = 12'h004;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h100;
    localparam logic [OFF_W-1:0] OFF_AUX     = 12'h104;
    localparam logic [OFF_W-1:0] OFF_TAG     = 12'h108;
    localparam logic [OFF_W-1:0] OFF_DAT     = 12'h10C;
    localparam logic [OFF_W-1:0] OFF_FSTART  = 12'hC00;
    localparam logic [OFF_W-1:0] OFF_FEND    = 12'hC04;
    localparam logic [OFF_W-1:0] OFF_MNT_LO  = 12'h730;
    localparam logic [OFF_W-1:0] OFF_MNT_HI  = 12'h800;
    localparam logic [OFF_W-1:0] OFF_RSV0    = 12'hF40;
    localparam logic [OFF_W-1:0] OFF_RSV1    = 12'hF60;
    localparam logic [OFF_W-1:0] OFF_RSV2    = 12'hF80;

    // Placement of the geometry code inside the geometry word
    localparam int CODE_W     = 4;
    localparam int CODE_HI_LSB = 18;
    localparam int CODE_LO_LSB = 6;

    typedef enum logic [3:0] {
        SEL_ID,
        SEL_TYPE,
        SEL_CTRL,
        SEL_AUX,
        SEL_TAG,
        SEL_DAT,
        SEL_FSTART,
        SEL_FEND,
        SEL_MAINT,
        SEL_RSVD,
        SEL_BAD
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] tag;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] fstart;
        logic [DATA_W-1:0] fend;
    } cfg_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_out_t;

endpackage

// File: rtl/stub_l2_decode.sv
module stub_l2_decode
    import stub_l2_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    output reg_sel_e         sel
);

    logic in_maint;

    always_comb begin
        in_maint = (offset >= OFF_MNT_LO) && (offset < OFF_MNT_HI);
        if (in_maint) begin
            sel = SEL_MAINT;
        end else begin
            unique case (offset)
                OFF_ID:     sel = SEL_ID;
                OFF_TYPE:   sel = SEL_TYPE;
                OFF_CTRL:   sel = SEL_CTRL;
                OFF_AUX:    sel = SEL_AUX;
                OFF_TAG:    sel = SEL_TAG;
                OFF_DAT:    sel = SEL_DAT;
                OFF_FSTART: sel = SEL_FSTART;
                OFF_FEND:   sel = SEL_FEND;
                OFF_RSV0,
                OFF_RSV1,
                OFF_RSV2:   sel = SEL_RSVD;
                default:    sel = SEL_BAD;
            endcase
        end
    end

endmodule

// File: rtl/stub_l2_cfg.sv
module stub_l2_cfg
    import stub_l2_pkg::*;
#(
    parameter logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_regs_t         regs
);

    localparam logic [DATA_W-1:0] CTRL_KEEP = {{(DATA_W-1){1'b0}}, 1'b1};

    cfg_regs_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL:   cfg_d.ctrl   = wdata & CTRL_KEEP;
                SEL_AUX:    cfg_d.aux    = wdata;
                SEL_TAG:    cfg_d.tag    = wdata;
                SEL_DAT:    cfg_d.dat    = wdata;
                SEL_FSTART: cfg_d.fstart = wdata;
                SEL_FEND:   cfg_d.fend   = wdata;
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.aux    <= AUX_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign regs = cfg_q;

endmodule

// File: rtl/stub_l2_type.sv
module stub_l2_type
    import stub_l2_pkg::*;
#(
    parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] aux,
    output logic [DATA_W-1:0] type_word,
    output logic [DATA_W-1:0] type_merged
);

    logic [DATA_W-1:0] type_d, type_q;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] code_spread;

    always_comb begin
        code        = {aux[19:17], aux[16]};
        code_spread = '0;
        code_spread[CODE_HI_LSB +: CODE_W] = code;
        code_spread[CODE_LO_LSB +: CODE_W] = code;
        type_merged = type_q | code_spread;
        type_d      = rd_fire ? type_merged : type_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= TYPE_RESET;
        end else begin
            type_q <= type_d;
        end
    end

    assign type_word = type_q;

endmodule

// File: rtl/stub_l2_regs.sv
module stub_l2_regs
    import stub_l2_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [DATA_W-1:0] ID_VALUE   = 32'h4100_00C8,
    parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100,
    parameter logic [DATA_W-1:0] AUX_RESET  = 32'h0202_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);

    reg_sel_e          sel;
    cfg_regs_t         regs;
    logic [DATA_W-1:0] type_val;
    logic [DATA_W-1:0] type_merged;
    logic [DATA_W-1:0] rd_value;
    bus_out_t          out_d, out_q;

    stub_l2_decode u_decode (
        .offset (bus_addr[OFF_W-1:0]),
        .sel    (sel)
    );

    stub_l2_cfg #(
        .AUX_RESET (AUX_RESET)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we),
        .sel   (sel),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    stub_l2_type #(
        .TYPE_RESET (TYPE_RESET)
    ) u_type (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire     (bus_re && (sel == SEL_TYPE)),
        .aux         (regs.aux),
        .type_word   (type_val),
        .type_merged (type_merged)
    );

    always_comb begin
        case (sel)
            SEL_ID:     rd_value = ID_VALUE;
            SEL_TYPE:   rd_value = type_merged;
            SEL_CTRL:   rd_value = regs.ctrl;
            SEL_AUX:    rd_value = regs.aux;
            SEL_TAG:    rd_value = regs.tag;
            SEL_DAT:    rd_value = regs.dat;
            SEL_FSTART: rd_value = regs.fstart;
            SEL_FEND:   rd_value = regs.fend;
            default:    rd_value = '0;
        endcase
        out_d.rdata = bus_re ? rd_value : '0;
        out_d.err   = (bus_re || bus_we) && (sel == SEL_BAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_rdata = out_q.rdata;
    assign bus_err   = out_q.err;

endmodule

// File: rtl/stub_l2_regs_chk.sv
module stub_l2_regs_chk #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h4100_00C8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       type_val
);

    logic [11:0] off;
    logic        is_maint;
    logic        is_rsvd;
    logic        is_mapped;

    always_comb begin
        off       = bus_addr[11:0];
        is_maint  = (off >= 12'h730) && (off <= 12'h7FF);
        is_rsvd   = (off == 12'hF40) || (off == 12'hF60) || (off == 12'hF80);
        is_mapped = is_maint || is_rsvd ||
                    (off == 12'h000) || (off == 12'h004) ||
                    (off == 12'h100) || (off == 12'h104) ||
                    (off == 12'h108) || (off == 12'h10C) ||
                    (off == 12'hC00) || (off == 12'hC04);
    end

    p_id_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && off == 12'h000) |-> bus_rdata == ID_VALUE);

    p_ctrl_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && off == 12'h100) |-> bus_rdata[31:1] == 31'd0);

    p_type_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (type_val & $past(type_val)) == $past(type_val));

    p_maint_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && is_maint) |-> bus_rdata == 32'd0);

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && is_rsvd) |-> bus_rdata == 32'd0);

    p_bad_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bus_err == $past((bus_re || bus_we) && !is_mapped));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_re) |-> bus_rdata == 32'd0);

endmodule

bind stub_l2_regs stub_l2_regs_chk #(
    .ADDR_W   (ADDR_W),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .type_val  (type_val)
);

// File: tb/stub_l2_regs_bench.sv
module stub_l2_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    stub_l2_regs u_stub_l2_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        bus_re = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One bus cycle; results sampled at the following negedge
    task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                          input logic re, output logic [31:0] rd, output logic err);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        bus_re    = re;
        @(negedge clk);
        rd = bus_rdata;
        err = bus_err;
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, output logic err);
        logic [31:0] rd;
        access(a, 1'b1, d, 1'b0, rd, err);
    endtask

    task automatic rdr(input logic [31:0] a, output logic [31:0] d, output logic err);
        access(a, 1'b0, '0, 1'b1, d, err);
    endtask

    task automatic t_reset_values();
        logic [31:0] d; logic e;
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 32'h0);
        rdr(32'h100, d, e); check("R5 ctrl reset", d, 32'h0);
        rdr(32'h104, d, e); check("R5 aux reset", d, 32'h0202_0000);
        rdr(32'h108, d, e); check("R5 tag reset", d, 32'h0);
        rdr(32'h10C, d, e); check("R5 data reset", d, 32'h0);
        rdr(32'hC00, d, e); check("R5 fstart reset", d, 32'h0);
        rdr(32'hC04, d, e); check("R5 fend reset", d, 32'h0);
        rdr(32'h004, d, e); check("R6 first type read", d, 32'h1C18_0180);
    endtask

    task automatic t_ident();
        logic [31:0] d; logic e;
        rdr(32'h000, d, e); check("R2 id", d, 32'h4100_00C8);
        wr(32'h000, 32'hDEAD_BEEF, e); check("R2 id write err", {31'd0, e}, 32'h0);
        rdr(32'h000, d, e); check("R2 id after write", d, 32'h4100_00C8);
    endtask

    task automatic t_ctrl();
        logic [31:0] d; logic e;
        wr(32'h100, 32'hFFFF_FFFF, e);
        rdr(32'h100, d, e); check("R3 ctrl all ones", d, 32'h1);
        wr(32'h100, 32'hFFFF_FFFE, e);
        rdr(32'h100, d, e); check("R3 ctrl bit0 clear", d, 32'h0);
    endtask

    task automatic t_full_regs();
        logic [31:0] d; logic e;
        wr(32'h108, 32'hA5A5_5A5A, e);
        wr(32'h10C, 32'h1234_5678, e);
        wr(32'hC00, 32'hFFFF_FFFF, e);
        wr(32'hC04, 32'h8000_0001, e);
        wr(32'h104, 32'h0F0F_F0F0, e);
        rdr(32'h108, d, e); check("R4 tag", d, 32'hA5A5_5A5A);
        rdr(32'h10C, d, e); check("R4 data", d, 32'h1234_5678);
        rdr(32'hC00, d, e); check("R4 fstart", d, 32'hFFFF_FFFF);
        rdr(32'hC04, d, e); check("R4 fend", d, 32'h8000_0001);
        rdr(32'h104, d, e); check("R4 aux", d, 32'h0F0F_F0F0);
    endtask

    task automatic t_alias();
        logic [31:0] d; logic e;
        wr(32'hABCD_5104, 32'h0000_0042, e);
        rdr(32'h0000_0104, d, e); check("R1 alias write", d, 32'h0000_0042);
        rdr(32'h7777_3000, d, e); check("R1 alias id", d, 32'h4100_00C8);
    endtask

    task automatic t_type_sticky();
        logic [31:0] d; logic e;
        apply_reset();
        rdr(32'h004, d, e); check("R6 type after reset", d, 32'h1C18_0180);
        wr(32'h104, 32'h0001_0000, e);
        rdr(32'h004, d, e); check("R6 type bit16 code", d, 32'h1C1C_01C0);
        wr(32'h104, 32'h0, e);
        rdr(32'h004, d, e); check("R7 type keeps bits", d, 32'h1C1C_01C0);
        wr(32'h104, 32'h000E_0000, e);
        rdr(32'h004, d, e); check("R6 type bits19..17", d, 32'h1C3C_03C0);
        apply_reset();
        rdr(32'h004, d, e); check("R7 reset clears type", d, 32'h1C18_0180);
    endtask

    task automatic t_maint();
        logic [31:0] d; logic e;
        wr(32'h730, 32'hFFFF_FFFF, e); check("R8 maint write err", {31'd0, e}, 32'h0);
        rdr(32'h730, d, e); check("R8 maint low read", d, 32'h0);
        check("R8 maint low err", {31'd0, e}, 32'h0);
        rdr(32'h7FC, d, e); check("R8 maint high read", d, 32'h0);
        rdr(32'h72C, d, e); check("R8 below range is bad", {31'd0, e}, 32'h1);
        rdr(32'h800, d, e); check("R8 above range is bad", {31'd0, e}, 32'h1);
    endtask

    task automatic t_reserved();
        logic [31:0] d; logic e;
        wr(32'hF40, 32'h1, e); check("R9 F40 write err", {31'd0, e}, 32'h0);
        rdr(32'hF40, d, e); check("R9 F40 read", d, 32'h0);
        rdr(32'hF60, d, e); check("R9 F60 read", d, 32'h0);
        check("R9 F60 err", {31'd0, e}, 32'h0);
        rdr(32'hF80, d, e); check("R9 F80 read", d, 32'h0);
    endtask

    task automatic t_bad();
        logic [31:0] d; logic e;
        wr(32'h104, 32'h5555_AAAA, e);
        rdr(32'h200, d, e);
        check("R10 bad read data", d, 32'h0);
        check("R10 bad read err", {31'd0, e}, 32'h1);
        @(negedge clk);
        check("R10 err one cycle", {31'd0, bus_err}, 32'h0);
        wr(32'h204, 32'hFFFF_FFFF, e); check("R10 bad write err", {31'd0, e}, 32'h1);
        rdr(32'h104, d, e); check("R10 aux untouched", d, 32'h5555_AAAA);
        check("R10 good read no err", {31'd0, e}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d; logic e;
        wr(32'h108, 32'h0000_1111, e);
        access(32'h108, 1'b1, 32'h0000_2222, 1'b1, d, e);
        check("R11 read returns old", d, 32'h0000_1111);
        @(negedge clk);
        check("R11 rdata zero after idle", bus_rdata, 32'h0);
        rdr(32'h108, d, e); check("R11 new value visible", d, 32'h0000_2222);
    endtask

    initial begin
        apply_reset();
        t_reset_values();
        t_ident();
        t_ctrl();
        t_full_regs();
        t_alias();
        t_type_sticky();
        t_maint();
        t_reserved();
        t_bad();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule